// File: doc/BRIEF.md
# Single-Channel Fly-By DMA Transfer Controller

This block moves a run of data words between a memory and one I/O device. Software programs a start address, a word count, a direction and a transfer mode. The device then requests service with `dreq`, and the controller answers with `dack`. The device needs no address of its own: `dack` together with an I/O read or write strobe selects it. The memory address bus therefore always carries the controller's current memory pointer.

The block has two transfer modes. In fly-by mode, each word needs a single bus cycle. The memory strobe and the opposite I/O strobe are raised together, and the data passes straight from source to destination. In two-cycle mode, the first bus cycle reads the source into an internal holding register, and the second writes that register to the destination. Fly-by mode therefore doubles the transfer rate for the same clock.

When the count runs out, the controller sets `done` and stops. While `dreq` is low, it waits at a word boundary. Disabling the channel aborts a half-finished two-cycle transfer and clears the holding register.

Top module: `fbdma_ctrl`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `io_rd`, `io_wr`, `dack` and `done` are low and `mem_addr` is zero.
- R2: In fly-by mode with direction memory-to-device, each word takes one cycle in which `mem_rd` and `io_wr` are both high, and `io_wdata` carries `mem_rdata` of that cycle.
- R3: In fly-by mode with direction device-to-memory, each word takes one cycle in which `io_rd` and `mem_wr` are both high, and `mem_wdata` carries `io_rdata` of that cycle.
- R4: In two-cycle mode, each word takes two cycles. The first raises only the source read strobe and captures the source data. The second raises only the destination write strobe and drives the captured word.
- R5: While a transfer runs, `mem_addr` shows the current memory address. The address advances by one, modulo 2^AW, after each completed word.
- R6: After the programmed number of words, `done` rises and `dack` is low. Enabling with a count of zero sets `done` without any strobe.
- R7: With `dreq` held high, a run of N words keeps `dack` high for N consecutive cycles in fly-by mode and for 2N consecutive cycles in two-cycle mode.
- R8: A word starts only while the channel is enabled and `dreq` is high. A low `dreq` stops the run only at a word boundary, and a two-cycle word that has been read is always written.
- R9: Disabling the channel while a two-cycle word has been read but not written drops that word and clears the holding register, so that `io_wdata`/`mem_wdata` read zero in two-cycle mode. After re-enabling, the first strobe is a read.
- R10: While the channel is enabled and not done, writes to the address and count registers are ignored. Control writes can then change only the enable bit.
- R11: A strobe is high only while `dack` is high. A read strobe and a write strobe of the same side are never high together.
- R12: `cfg_sel` selects the register: 0 is address, 1 is count, 2 is control. In the control register, bit 0 is enable, bit 1 is direction (1 = device-to-memory) and bit 2 is mode (1 = two-cycle). A control write with enable set, made while the channel is not active, clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Programming write strobe |
| cfg_sel | input | 2 | Programming register select |
| cfg_wdata | input | PW | Programming write data |
| dreq | input | 1 | Service request from device |
| dack | output | 1 | Service acknowledge to device, high in every transfer cycle |
| done | output | 1 | Run complete |
| mem_addr | output | AW | Memory address, current pointer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, valid in the strobed cycle |
| mem_wdata | output | DW | Memory write data |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| io_rdata | input | DW | Device read data, valid in the strobed cycle |
| io_wdata | output | DW | Device write data |

## Verification
The bench builds the controller with 8-bit address, count, data and programming widths, and with the holding-register variant included. The 8-bit address lets a three-word run cross the top of memory and wrap to zero. The short counts keep every two-cycle run, pause and abort case to a few dozen cycles, so cycle-exact `dack` lengths can be compared between the two modes.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FLY   = 2'd1,
      ST_FETCH = 2'd2,
      ST_STORE = 2'd3
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   localparam int CB_EN      = 0;
   localparam int CB_DIR     = 1;
   localparam int CB_MODE    = 2;
   localparam int CTRL_BITS  = 3;

endpackage

// File: rtl/fbdma_regs.sv
module fbdma_regs
   import fbdma_pkg::*;
#(
   parameter int AW            = 16,
   parameter int CW            = 16,
   parameter int PW            = 16,
   parameter bit HAS_TWO_CYCLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [PW-1:0] cfg_wdata,
   input  logic          step,
   input  logic          zero_done,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] count,
   output logic          dir,
   output logic          two_cycle,
   output logic          en_nxt,
   output logic          active,
   output logic          done
);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] cnt_q;
   logic          en_q, dir_q, mode_q, done_q;
   logic          ctrl_wr;
   logic          mode_bit;
   logic          unused_wdata;

   assign unused_wdata = ^cfg_wdata;
   assign ctrl_wr      = cfg_we && (cfg_sel == SEL_CTRL);
   assign active       = en_q && !done_q;
   assign en_nxt       = ctrl_wr ? cfg_wdata[CB_EN] : en_q;

   generate
      if (HAS_TWO_CYCLE) begin : g_mode_sel
         assign mode_bit = cfg_wdata[CB_MODE];
      end else begin : g_mode_fixed
         assign mode_bit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         en_q   <= 1'b0;
         dir_q  <= 1'b0;
         mode_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) done_q <= 1'b1;
         end
         if (zero_done) done_q <= 1'b1;
         if (cfg_we && !active) begin
            case (cfg_sel)
               SEL_ADDR:  addr_q <= cfg_wdata[AW-1:0];
               SEL_COUNT: cnt_q  <= cfg_wdata[CW-1:0];
               SEL_CTRL: begin
                  dir_q  <= cfg_wdata[CB_DIR];
                  mode_q <= mode_bit;
                  if (cfg_wdata[CB_EN]) done_q <= 1'b0;
               end
               default: ;
            endcase
         end
         if (ctrl_wr) en_q <= cfg_wdata[CB_EN];
      end
   end

   assign addr      = addr_q;
   assign count     = cnt_q;
   assign dir       = dir_q;
   assign two_cycle = mode_q;
   assign done      = done_q;

   // R5: pointer advances by one after each completed word
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (addr_q == $past(addr_q) + AW'(1)));

   // R10: an active channel keeps its programming between words
   p_busy_regs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !step) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(dir_q) && $stable(mode_q)));

   // R6: the last word raises done
   p_last_sets_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == CW'(1)) |=> done_q);

endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq
   import fbdma_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          en_nxt,
   input  logic          dreq,
   input  logic          two_cycle,
   input  logic [CW-1:0] count,
   output seq_state_t    state,
   output logic          step,
   output logic          zero_done,
   output logic          latch,
   output logic          hold_clr
);

   seq_state_t state_q, state_d;
   logic       cnt_zero, cnt_last, go_on;

   assign cnt_zero = (count == '0);
   assign cnt_last = (count == CW'(1));
   assign go_on    = en_nxt && dreq && !cnt_last;
   assign hold_clr = !en_nxt;

   always_comb begin
      state_d   = state_q;
      step      = 1'b0;
      zero_done = 1'b0;
      latch     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (active && en_nxt) begin
               if (cnt_zero)  zero_done = 1'b1;
               else if (dreq) state_d = two_cycle ? ST_FETCH : ST_FLY;
            end
         end
         ST_FLY: begin
            step    = 1'b1;
            state_d = go_on ? ST_FLY : ST_IDLE;
         end
         ST_FETCH: begin
            if (!en_nxt) begin
               state_d = ST_IDLE;
            end else begin
               latch   = 1'b1;
               state_d = ST_STORE;
            end
         end
         ST_STORE: begin
            step    = 1'b1;
            state_d = go_on ? ST_FETCH : ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // R4: a read phase is followed by its write phase unless aborted
   p_fetch_leads_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH) |=> (state_q == ST_STORE || state_q == ST_IDLE));

   // R8: low request ends the run at a word boundary
   p_dreq_low_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_FLY || state_q == ST_STORE) && !dreq) |=> (state_q == ST_IDLE));

   // R8: no word starts without a request
   p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !dreq) |=> (state_q == ST_IDLE));

   // R9: disabling during a read phase abandons the word
   p_disable_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FETCH && !en_nxt) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/fbdma_hold.sv
module fbdma_hold #(
   parameter int DW            = 8,
   parameter bit HAS_TWO_CYCLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          latch,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] hold
);

   generate
      if (HAS_TWO_CYCLE) begin : g_hold_reg
         logic [DW-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hold_q <= '0;
            else if (clr)   hold_q <= '0;
            else if (latch) hold_q <= din;
         end
         assign hold = hold_q;

         // R9: a disabled channel keeps no stale word
         p_hold_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (hold_q == '0));
      end else begin : g_no_hold
         logic unused_hold;
         assign unused_hold = clk ^ rst_n ^ clr ^ latch ^ (^din);
         assign hold        = '0;
      end
   endgenerate

endmodule

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl
   import fbdma_pkg::*;
#(
   parameter int AW            = 16,
   parameter int DW            = 8,
   parameter int CW            = 16,
   parameter int PW            = 16,
   parameter bit HAS_TWO_CYCLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [PW-1:0] cfg_wdata,
   input  logic          dreq,
   output logic          dack,
   output logic          done,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] mem_wdata,
   output logic          io_rd,
   output logic          io_wr,
   input  logic [DW-1:0] io_rdata,
   output logic [DW-1:0] io_wdata
);

   generate
      if (PW < AW) begin : g_bad_aw
         $error("fbdma_ctrl: PW must cover AW");
      end
      if (PW < CW) begin : g_bad_cw
         $error("fbdma_ctrl: PW must cover CW");
      end
      if (PW < CTRL_BITS) begin : g_bad_ctrl
         $error("fbdma_ctrl: PW too narrow for control bits");
      end
      if (DW < 1 || AW < 1 || CW < 1) begin : g_bad_w
         $error("fbdma_ctrl: widths must be positive");
      end
   endgenerate

   logic [CW-1:0] count;
   logic          dir, two_cycle, en_nxt, active;
   logic          step, zero_done, latch, hold_clr;
   seq_state_t    state;
   logic [DW-1:0] hold, cap_src;
   logic          rd_phase, wr_phase;

   fbdma_regs #(
      .AW(AW), .CW(CW), .PW(PW), .HAS_TWO_CYCLE(HAS_TWO_CYCLE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .step      (step),
      .zero_done (zero_done),
      .addr      (mem_addr),
      .count     (count),
      .dir       (dir),
      .two_cycle (two_cycle),
      .en_nxt    (en_nxt),
      .active    (active),
      .done      (done)
   );

   fbdma_seq #(
      .CW(CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .en_nxt    (en_nxt),
      .dreq      (dreq),
      .two_cycle (two_cycle),
      .count     (count),
      .state     (state),
      .step      (step),
      .zero_done (zero_done),
      .latch     (latch),
      .hold_clr  (hold_clr)
   );

   assign cap_src = dir ? io_rdata : mem_rdata;

   fbdma_hold #(
      .DW(DW), .HAS_TWO_CYCLE(HAS_TWO_CYCLE)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hold_clr),
      .latch (latch),
      .din   (cap_src),
      .hold  (hold)
   );

   assign rd_phase = (state == ST_FLY) || (state == ST_FETCH);
   assign wr_phase = (state == ST_FLY) || (state == ST_STORE);

   assign dack      = (state != ST_IDLE);
   assign mem_rd    = !dir && rd_phase;
   assign io_wr     = !dir && wr_phase;
   assign io_rd     =  dir && rd_phase;
   assign mem_wr    =  dir && wr_phase;
   assign io_wdata  = two_cycle ? hold : mem_rdata;
   assign mem_wdata = two_cycle ? hold : io_rdata;

   // R11: strobes only under acknowledge
   p_strobe_dack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |-> dack);

   // R11: one side never reads and writes at once
   p_side_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr) && !(io_rd && io_wr));

   // R2: fly-by memory read pairs with device write
   p_flyby_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !two_cycle) |-> io_wr);

   // R3: fly-by device read pairs with memory write
   p_flyby_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !two_cycle) |-> mem_wr);

   // R4: two-cycle never merges read and write
   p_two_cycle_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
      two_cycle |-> (!(mem_rd && io_wr) && !(io_rd && mem_wr)));

   // R6: a finished channel does not acknowledge
   p_done_no_dack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dack);

endmodule

// File: tb/tb_fbdma_ctrl.sv
`timescale 1ns/1ps
module tb_fbdma_ctrl;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int CW = 8;
   localparam int PW = 8;
   localparam int NV = 6;

   // {addr, count, dir, mode}
   localparam logic [17:0] VEC [NV] = '{
      {8'h10, 8'd5, 1'b0, 1'b0},
      {8'h40, 8'd4, 1'b1, 1'b0},
      {8'h60, 8'd3, 1'b0, 1'b1},
      {8'h90, 8'd6, 1'b1, 1'b1},
      {8'hFE, 8'd3, 1'b0, 1'b0},
      {8'h01, 8'd1, 1'b1, 1'b1}
   };

   logic          clk, rst_n;
   logic          cfg_we;
   logic [1:0]    cfg_sel;
   logic [PW-1:0] cfg_wdata;
   logic          dreq, dack, done;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, io_rd, io_wr;
   logic [DW-1:0] mem_rdata, mem_wdata, io_rdata, io_wdata;

   int n_chk  = 0;
   int n_fail = 0;

   fbdma_ctrl #(
      .AW(AW), .DW(DW), .CW(CW), .PW(PW), .HAS_TWO_CYCLE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .done(done),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .io_rd(io_rd),
      .io_wr(io_wr), .io_rdata(io_rdata), .io_wdata(io_wdata)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   function automatic logic [7:0] mem_pat(input logic [7:0] a);
      return a ^ 8'h5A;
   endfunction

   function automatic logic [7:0] src_pat(input logic [7:0] k);
      return k * 8'd7 + 8'd3;
   endfunction

   // memory and device models
   logic [7:0] mem     [256];
   logic [7:0] dev_log [256];
   logic [7:0] dev_ptr;
   int         log_n;
   logic       model_clr;

   always @(posedge clk) begin
      if (model_clr) begin
         for (int i = 0; i < 256; i++) mem[i] <= mem_pat(8'(i));
         dev_ptr <= '0;
         log_n   <= 0;
      end else begin
         if (mem_wr) mem[mem_addr] <= mem_wdata;
         if (io_rd)  dev_ptr <= dev_ptr + 8'd1;
         if (io_wr) begin
            dev_log[8'(log_n)] <= io_wdata;
            log_n <= log_n + 1;
         end
      end
   end

   assign mem_rdata = mem[mem_addr];
   assign io_rdata  = src_pat(dev_ptr);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_models();
      @(negedge clk); model_clr = 1'b1;
      @(negedge clk); model_clr = 1'b0;
   endtask

   task automatic wait_done();
      for (int c = 0; c < 200; c++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   task automatic run_vector(input int idx);
      logic [7:0] a0, n;
      logic       dr, md;
      int dk, rd, wr, both, xf, aerr, derr;
      string tag;
      {a0, n, dr, md} = VEC[idx];
      tag = md ? "R4" : (dr ? "R3" : "R2");
      dk = 0; rd = 0; wr = 0; both = 0; xf = 0; aerr = 0; derr = 0;
      clear_models();
      dreq = 1'b0;
      cfg_write(2'd0, a0);
      cfg_write(2'd1, n);
      dreq = 1'b1;
      cfg_write(2'd2, {5'b0, md, dr, 1'b1});
      chk(done == 1'b0, "R12", int'(done), 0);
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (done) break;
         if (dack) dk++;
         if (mem_rd || io_rd) rd++;
         if (mem_wr || io_wr) wr++;
         if ((mem_rd || io_rd) && (mem_wr || io_wr)) both++;
         if ((mem_rd || mem_wr) && mem_addr != 8'(a0 + xf)) aerr++;
         if (mem_wr || io_wr) xf++;
      end
      chk(dk == (md ? 2 : 1) * int'(n), "R7", dk, (md ? 2 : 1) * int'(n));
      chk(rd == int'(n) && wr == int'(n), tag, rd + wr, 2 * int'(n));
      chk(both == (md ? 0 : int'(n)), tag, both, md ? 0 : int'(n));
      chk(aerr == 0, "R5", aerr, 0);
      chk(mem_addr == 8'(a0 + n), "R5", int'(mem_addr), int'(8'(a0 + n)));
      chk(done && !dack, "R6", int'(done), 1);
      for (int k = 0; k < int'(n); k++) begin
         if (!dr) begin
            if (dev_log[k] != mem_pat(8'(a0 + k))) derr++;
         end else begin
            if (mem[8'(a0 + k)] != src_pat(8'(k))) derr++;
         end
      end
      chk(derr == 0, tag, derr, 0);
      dreq = 1'b0;
   endtask

   task automatic run_all();
      int bad;
      // R1: reset state
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !io_rd && !io_wr, "R1", int'({mem_rd, mem_wr, io_rd, io_wr}), 0);
      chk(!dack && !done, "R1", int'({dack, done}), 0);
      chk(mem_addr == 8'h00, "R1", int'(mem_addr), 0);

      // main table: R2 R3 R4 R5 R6 R7 R12
      for (int v = 0; v < NV; v++) run_vector(v);

      // R6: zero count finishes with no strobe
      clear_models();
      cfg_write(2'd0, 8'h33);
      cfg_write(2'd1, 8'h00);
      dreq = 1'b1;
      cfg_write(2'd2, 8'h01);
      bad = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (dack || mem_rd || mem_wr || io_rd || io_wr) bad++;
      end
      chk(bad == 0 && done, "R6", bad, 0);
      chk(mem_addr == 8'h33, "R5", int'(mem_addr), 'h33);

      // R10 and R8: ignored writes, then fly-by pause
      dreq = 1'b0;
      clear_models();
      cfg_write(2'd0, 8'h20);
      cfg_write(2'd1, 8'd4);
      cfg_write(2'd2, 8'h01);
      @(negedge clk);
      chk(!dack, "R8", int'(dack), 0);
      cfg_write(2'd0, 8'h80);
      cfg_write(2'd1, 8'd1);
      cfg_write(2'd2, 8'h07);
      chk(mem_addr == 8'h20, "R10", int'(mem_addr), 'h20);
      dreq = 1'b1;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (dack) break;
      end
      chk(mem_rd && io_wr && mem_addr == 8'h20, "R10", int'(mem_addr), 'h20);
      @(negedge clk);
      dreq = 1'b0;
      @(negedge clk);
      chk(!dack && log_n == 2, "R8", log_n, 2);
      chk(mem_addr == 8'h22, "R8", int'(mem_addr), 'h22);
      bad = 0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         if (dack || mem_rd || io_wr) bad++;
      end
      chk(bad == 0, "R8", bad, 0);
      dreq = 1'b1;
      wait_done();
      chk(log_n == 4, "R10", log_n, 4);
      bad = 0;
      for (int k = 0; k < 4; k++) if (dev_log[k] != mem_pat(8'(8'h20 + k))) bad++;
      chk(bad == 0, "R10", bad, 0);
      dreq = 1'b0;

      // R8: two-cycle pause after a read completes the word
      clear_models();
      cfg_write(2'd0, 8'h50);
      cfg_write(2'd1, 8'd3);
      dreq = 1'b1;
      cfg_write(2'd2, 8'h05);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (mem_rd) break;
      end
      dreq = 1'b0;
      @(negedge clk);
      chk(io_wr && !mem_rd, "R8", int'(io_wr), 1);
      @(negedge clk);
      chk(!dack && log_n == 1, "R8", log_n, 1);
      repeat (3) @(negedge clk);
      dreq = 1'b1;
      wait_done();
      bad = 0;
      for (int k = 0; k < 3; k++) if (dev_log[k] != mem_pat(8'(8'h50 + k))) bad++;
      chk(log_n == 3 && bad == 0, "R4", bad, 0);
      dreq = 1'b0;

      // R9: disable during a read phase
      clear_models();
      cfg_write(2'd0, 8'h70);
      cfg_write(2'd1, 8'd4);
      dreq = 1'b1;
      cfg_write(2'd2, 8'h05);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (io_wr) break;
      end
      @(negedge clk);
      chk(mem_rd && !io_wr, "R4", int'(mem_rd), 1);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h04;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(!dack && !io_wr, "R9", int'(dack), 0);
      chk(io_wdata == 8'h00, "R9", int'(io_wdata), 0);
      chk(log_n == 1, "R9", log_n, 1);
      cfg_write(2'd2, 8'h05);
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (mem_rd || io_wr) break;
      end
      chk(mem_rd && !io_wr, "R9", int'(io_wr), 0);
      wait_done();
      bad = 0;
      for (int k = 0; k < 4; k++) if (dev_log[k] != mem_pat(8'(8'h70 + k))) bad++;
      chk(log_n == 4 && bad == 0, "R9", bad, 0);
      chk(mem_addr == 8'h74, "R5", int'(mem_addr), 'h74);
      dreq = 1'b0;
      // R11 is covered by the strobe checks above and by design assertions
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
      dreq = 1'b0; model_clr = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      model_clr = 1'b0;
      fork
         run_all();
         begin
            repeat (60000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule